// File: doc/BRIEF.md
# Serial Management Target for a 10/100 PHY

This block is the management end of the two-wire serial interface of a 10/100 Ethernet transceiver. The station toggles a management clock and shifts frames on a shared bidirectional data line. The block runs in the system clock domain, where it oversamples both wires. It decodes read and write frames that carry its own PHY address. For reads it returns data by driving the line through an output enable.

Three registers are visible. The control register sits at 00h. Its bit 10 is the isolate flag, which goes out to the data path, and its bit 15 is a self-clearing soft reset. The status register sits at 01h; it is read-only and advertises that preamble can be omitted. A read-only address register holds the five strap inputs, which are captured while reset is asserted. A strapped address of 00000 makes isolate come out of reset set.

A frame is built as follows: idle ones, start `01`, an opcode (`10` read, `01` write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits. Every field is sent MSB first. After reset the block needs one run of 32 consecutive ones before it decodes anything. From then on, frames without preamble are accepted, but consecutive frames must be separated by at least one idle one.

Top module: `smi_target`

## Requirements
- R1: The PHY address is taken from `strap_addr` while `rst_n` is low. Only frames carrying that address are answered. The register at `ADDR_REG` (default 19h) reads as the captured address in bits 4:0, with zeros above.
- R2: Right after reset, `isolate` (control bit 10) is 1 when the captured address is 00000 and 0 for any other address.
- R3: After reset, no frame is decoded until 32 consecutive ones have been sampled. After that, a frame with no preamble at all is accepted.
- R4: On a matching read, the line is released during the first turnaround bit and driven 0 during the second. The 16 data bits follow MSB first, and the line is released before the next bit period.
- R5: On a write (opcode 01), `mdio_oe` stays low for the whole frame, and the control register takes the written value. Writing 1 to bit 10 raises `isolate`.
- R6: A frame whose PHY address differs from the captured one never drives the line and never changes a register.
- R7: The status register at 01h reads 7849h by default, with bit 6 = 1. Writes to it have no effect.
- R8: A read of any unimplemented register address returns 0000h.
- R9: A start bit that immediately follows the last data bit of a frame, with no idle one in between, begins a frame that is not decoded. That frame's 32 bits are skipped.
- R10: Writing 1 to control bit 15 restores the control default of 3100h, with isolate re-derived from the captured address. Bit 15 then reads 0.
- R11: Reads and writes keep working while isolate is set, including at PHY address 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the management wires |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strap_addr | input | 5 | PHY address strap inputs |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Sampled value of the shared data line |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| isolate | output | 1 | Control bit 10, for the data path |

## Verification
The hardest condition to create is a frame that starts with no idle gap. It only arises when the station places a start bit in the very next period after the last data bit of a decoded frame. The bench builds it by running a valid read with zero trailing idle bits and following it at once with a preamble-less write. The write's effect, or lack of one, is then read back after an idle bit. The pre-initialization state is reached from a fresh reset, using frames whose released turnaround and data bits leave fewer than 32 consecutive ones.

// File: rtl/smi_pkg.sv
package smi_pkg;
   typedef enum logic [2:0] {
      ST_INIT, ST_IDLE, ST_START, ST_HDR, ST_TA, ST_DATA, ST_POST, ST_SKIP
   } smi_state_e;

   localparam int PHY_AW    = 5;
   localparam int REG_AW    = 5;
   localparam int DW        = 16;
   localparam int HDR_BITS  = 2 + PHY_AW + REG_AW;
   localparam int PRE_LEN   = 32;
   localparam int FRAME_LEN = 32;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   localparam logic [REG_AW-1:0] REG_CTRL = 5'h00;
   localparam logic [REG_AW-1:0] REG_STAT = 5'h01;

   localparam int ISO_BIT  = 10;
   localparam int SRST_BIT = 15;
   localparam int PSUP_BIT = 6;
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r <= {STAGES{RST_VAL}};
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smi_frame.sv
module smi_frame
   import smi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              bit_in,
   input  logic [PHY_AW-1:0] my_addr,
   input  logic [DW-1:0]     rd_data,
   output logic [REG_AW-1:0] reg_addr,
   output logic              wr_en,
   output logic [DW-1:0]     wr_data,
   output logic              mdio_out,
   output logic              mdio_oe
);
   localparam int CW = $clog2(FRAME_LEN);

   smi_state_e            st;
   logic [CW-1:0]         cnt;
   logic [HDR_BITS-2:0]   hdr;
   logic [HDR_BITS-1:0]   hdr_nxt;
   logic [DW-1:0]         sh;
   logic                  go_rd, go_wr;

   assign hdr_nxt  = {hdr, bit_in};
   assign reg_addr = (st == ST_HDR) ? hdr_nxt[REG_AW-1:0] : hdr[REG_AW-1:0];
   assign wr_data  = sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_INIT;
         cnt      <= '0;
         hdr      <= '0;
         sh       <= '0;
         go_rd    <= 1'b0;
         go_wr    <= 1'b0;
         wr_en    <= 1'b0;
         mdio_oe  <= 1'b0;
         mdio_out <= 1'b1;
      end else begin
         wr_en <= 1'b0;
         if (bit_tick) begin
            case (st)
               ST_INIT: begin
                  if (!bit_in)                       cnt <= '0;
                  else if (cnt == CW'(PRE_LEN - 1)) begin
                     st  <= ST_IDLE;
                     cnt <= '0;
                  end else                           cnt <= cnt + 1'b1;
               end
               ST_IDLE:  if (!bit_in) st <= ST_START;
               ST_START: begin
                  st  <= bit_in ? ST_HDR : ST_POST;
                  cnt <= '0;
               end
               ST_HDR: begin
                  hdr <= hdr_nxt[HDR_BITS-2:0];
                  if (cnt == CW'(HDR_BITS - 1)) begin
                     st    <= ST_TA;
                     cnt   <= '0;
                     go_rd <= (hdr_nxt[HDR_BITS-1 -: 2] == OP_RD) &&
                              (hdr_nxt[REG_AW +: PHY_AW] == my_addr);
                     go_wr <= (hdr_nxt[HDR_BITS-1 -: 2] == OP_WR) &&
                              (hdr_nxt[REG_AW +: PHY_AW] == my_addr);
                     sh    <= rd_data;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_TA: begin
                  if (cnt == '0) begin
                     cnt <= 1'b1;
                     if (go_rd) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                     end
                  end else begin
                     st       <= ST_DATA;
                     cnt      <= '0;
                     mdio_out <= sh[DW-1];
                     sh       <= {sh[DW-2:0], 1'b0};
                  end
               end
               ST_DATA: begin
                  sh       <= {sh[DW-2:0], bit_in};
                  mdio_out <= sh[DW-1];
                  if (cnt == CW'(DW - 1)) begin
                     st       <= ST_POST;
                     mdio_oe  <= 1'b0;
                     mdio_out <= 1'b1;
                     wr_en    <= go_wr;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_POST: begin
                  st  <= bit_in ? ST_IDLE : ST_SKIP;
                  cnt <= '0;
               end
               ST_SKIP: begin
                  if (cnt == CW'(FRAME_LEN - 2)) st <= ST_POST;
                  else                            cnt <= cnt + 1'b1;
               end
               default: st <= ST_INIT;
            endcase
         end
      end
   end
endmodule

// File: rtl/smi_regs.sv
module smi_regs
   import smi_pkg::*;
#(
   parameter logic [DW-1:0]     CTRL_RST   = 16'h3100,
   parameter logic [DW-1:0]     CTRL_WMASK = 16'h7FFF,
   parameter logic [DW-1:0]     STAT_VAL   = 16'h7809,
   parameter logic [REG_AW-1:0] ADDR_REG   = 5'h19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHY_AW-1:0] strap_addr,
   input  logic [REG_AW-1:0] reg_addr,
   output logic [DW-1:0]     rd_data,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   output logic [PHY_AW-1:0] phy_addr,
   output logic              isolate
);
   localparam logic [DW-1:0] ISO_M  = DW'(1) << ISO_BIT;
   localparam logic [DW-1:0] SRST_M = DW'(1) << SRST_BIT;
   localparam logic [DW-1:0] WMASK  = CTRL_WMASK & ~SRST_M;
   localparam logic [DW-1:0] STAT_R = STAT_VAL | (DW'(1) << PSUP_BIT);

   generate
      if (ADDR_REG == REG_CTRL || ADDR_REG == REG_STAT) begin : g_bad_addr
         $error("ADDR_REG collides with a fixed register");
      end
      if (CTRL_RST[SRST_BIT]) begin : g_bad_rst
         $error("CTRL_RST must leave the soft reset bit clear");
      end
   endgenerate

   function automatic logic [DW-1:0] ctrl_default(input logic [PHY_AW-1:0] a);
      return (CTRL_RST & ~ISO_M) | ((a == '0) ? ISO_M : '0);
   endfunction

   logic [DW-1:0] ctrl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_addr <= strap_addr;
         ctrl     <= ctrl_default(strap_addr);
      end else if (wr_en && reg_addr == REG_CTRL) begin
         if (wr_data[SRST_BIT]) ctrl <= ctrl_default(phy_addr);
         else                   ctrl <= (ctrl & ~WMASK) | (wr_data & WMASK);
      end
   end

   always_comb begin
      if (reg_addr == REG_CTRL)      rd_data = ctrl;
      else if (reg_addr == REG_STAT) rd_data = STAT_R;
      else if (reg_addr == ADDR_REG) rd_data = {{(DW-PHY_AW){1'b0}}, phy_addr};
      else                           rd_data = '0;
   end

   assign isolate = ctrl[ISO_BIT];
endmodule

// File: rtl/smi_target.sv
module smi_target
   import smi_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [DW-1:0]     CTRL_RST    = 16'h3100,
   parameter logic [DW-1:0]     CTRL_WMASK  = 16'h7FFF,
   parameter logic [DW-1:0]     STAT_VAL    = 16'h7809,
   parameter logic [REG_AW-1:0] ADDR_REG    = 5'h19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHY_AW-1:0] strap_addr,
   input  logic              mdc,
   input  logic              mdio_in,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic              isolate
);
   logic              mdc_q, mdio_q, mdc_prev, bit_tick;
   logic [REG_AW-1:0] reg_addr;
   logic [DW-1:0]     rd_data, wr_data;
   logic              wr_en;
   logic [PHY_AW-1:0] phy_addr;

   smi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(mdc), .q(mdc_q));
   smi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(mdio_in), .q(mdio_q));

   always_ff @(posedge clk) begin
      if (!rst_n) mdc_prev <= 1'b0;
      else        mdc_prev <= mdc_q;
   end
   assign bit_tick = mdc_q & ~mdc_prev;

   smi_frame u_frame (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_in(mdio_q),
      .my_addr(phy_addr), .rd_data(rd_data), .reg_addr(reg_addr),
      .wr_en(wr_en), .wr_data(wr_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe));

   smi_regs #(
      .CTRL_RST(CTRL_RST), .CTRL_WMASK(CTRL_WMASK),
      .STAT_VAL(STAT_VAL), .ADDR_REG(ADDR_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .reg_addr(reg_addr),
      .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
      .phy_addr(phy_addr), .isolate(isolate));
endmodule

// File: rtl/smi_target_chk.sv
module smi_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] strap_addr,
   input logic       mdc,
   input logic       mdio_in,
   input logic       mdio_out,
   input logic       mdio_oe,
   input logic       isolate
);
   logic       mdc_p, rise, seen32;
   logic [5:0] ones;
   logic [4:0] drv_rises;

   assign rise = mdc & ~mdc_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_p     <= 1'b0;
         ones      <= '0;
         seen32    <= 1'b0;
         drv_rises <= '0;
      end else begin
         mdc_p <= mdc;
         if (rise) begin
            if (!mdio_in)        ones <= '0;
            else if (ones < 6'd32) ones <= ones + 1'b1;
            if (mdio_in && ones == 6'd31) seen32 <= 1'b1;
         end
         if (!mdio_oe)  drv_rises <= '0;
         else if (rise) drv_rises <= drv_rises + 1'b1;
      end
   end

   // R3
   no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> seen32);

   // R4
   ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_out);

   // R4
   drive_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> drv_rises <= 5'd17);

   // R2
   iso_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> isolate == (strap_addr == 5'd0));

   // R5
   oe_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(mdio_oe));
endmodule

bind smi_target smi_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .mdc(mdc),
   .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .isolate(isolate));

// File: tb/smi_target_test.sv
module smi_target_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] strap = 5'h0B;
   logic       mdc = 1'b0;
   logic       sta_oe = 1'b1, sta_bit = 1'b1;
   logic       mdio_out, mdio_oe, isolate, bus;
   int         n_run = 0, n_fail = 0;

   localparam logic [1:0] RD = 2'b10, WR = 2'b01;

   always #2.5 clk = ~clk;

   assign bus = mdio_oe ? mdio_out : (sta_oe ? sta_bit : 1'b1);

   smi_target uut (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap), .mdc(mdc),
      .mdio_in(bus), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .isolate(isolate));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [4:0] s);
      rst_n = 1'b0; strap = s; mdc = 1'b0; sta_oe = 1'b1; sta_bit = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic mdc_cycle(input logic drv, input logic b, output logic smp, output logic oe_s);
      sta_oe = drv; sta_bit = b;
      repeat (5) @(negedge clk);
      smp = bus; oe_s = mdio_oe;
      mdc = 1'b1;
      repeat (5) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic xfer(input int pre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, input int idle,
                       output logic [15:0] rd, output logic ta_ok, output logic any_oe);
      logic s, o;
      logic [13:0] h;
      h = {2'b01, op, pa, ra};
      any_oe = 1'b0; rd = '0; ta_ok = 1'b1;
      for (int i = 0; i < pre; i++) begin mdc_cycle(1'b1, 1'b1, s, o); any_oe |= o; end
      for (int i = 13; i >= 0; i--) begin mdc_cycle(1'b1, h[i], s, o); any_oe |= o; end
      if (op == RD) begin
         mdc_cycle(1'b0, 1'b1, s, o); ta_ok = !o && s;   any_oe |= o;
         mdc_cycle(1'b0, 1'b1, s, o); ta_ok &= o && !s;  any_oe |= o;
      end else begin
         mdc_cycle(1'b1, 1'b1, s, o); any_oe |= o;
         mdc_cycle(1'b1, 1'b0, s, o); any_oe |= o;
      end
      for (int i = 15; i >= 0; i--) begin
         if (op == RD) mdc_cycle(1'b0, 1'b1, s, o);
         else          mdc_cycle(1'b1, wd[i], s, o);
         rd[i] = s; any_oe |= o;
      end
      for (int i = 0; i < idle; i++) begin
         mdc_cycle(1'b1, 1'b1, s, o);
         if (i == 0 && op == RD) ta_ok &= !o;
      end
      sta_oe = 1'b1; sta_bit = 1'b1;
   endtask

   task automatic t_reset_state;
      do_reset(5'h0B);
      chk("R2 isolate after reset, addr 0B", 16'(isolate), 16'h0);
      chk("R4 no drive after reset", 16'(mdio_oe), 16'h0);
   endtask

   task automatic t_init;
      logic [15:0] rd; logic ta, oe;
      xfer(0, RD, 5'h0B, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R3 read before init not driven", 16'(oe), 16'h0);
      xfer(0, WR, 5'h0B, 5'h00, 16'h0400, 1, rd, ta, oe);
      chk("R3 write before init ignored", 16'(isolate), 16'h0);
      xfer(32, RD, 5'h0B, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R3 read after 32 ones", rd, 16'h3100);
      chk("R4 turnaround and release", 16'(ta), 16'h1);
   endtask

   task automatic t_reads;
      logic [15:0] rd; logic ta, oe;
      xfer(0, RD, 5'h0B, 5'h01, 16'h0, 1, rd, ta, oe);
      chk("R7 status value, no preamble", rd, 16'h7849);
      chk("R3 preamble-less read answered", 16'(ta), 16'h1);
      xfer(0, RD, 5'h0B, 5'h19, 16'h0, 1, rd, ta, oe);
      chk("R1 address register", rd, 16'h000B);
      xfer(0, RD, 5'h0B, 5'h05, 16'h0, 1, rd, ta, oe);
      chk("R8 unimplemented reads zero", rd, 16'h0000);
   endtask

   task automatic t_write;
      logic [15:0] rd; logic ta, oe;
      xfer(0, WR, 5'h0B, 5'h00, 16'h2400, 1, rd, ta, oe);
      chk("R5 write never drives", 16'(oe), 16'h0);
      chk("R5 isolate set by write", 16'(isolate), 16'h1);
      xfer(0, RD, 5'h0B, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R5 control readback", rd, 16'h2400);
      xfer(0, WR, 5'h0B, 5'h01, 16'h0000, 1, rd, ta, oe);
      xfer(0, RD, 5'h0B, 5'h01, 16'h0, 1, rd, ta, oe);
      chk("R7 status ignores writes", rd, 16'h7849);
   endtask

   task automatic t_mismatch;
      logic [15:0] rd; logic ta, oe;
      xfer(0, WR, 5'h0C, 5'h00, 16'h0000, 1, rd, ta, oe);
      chk("R6 foreign write no drive", 16'(oe), 16'h0);
      chk("R6 foreign write no effect", 16'(isolate), 16'h1);
      xfer(0, RD, 5'h0C, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R6 foreign read not driven", 16'(oe), 16'h0);
      chk("R6 foreign read bus idle", rd, 16'hFFFF);
   endtask

   task automatic t_idle_gap;
      logic [15:0] rd; logic ta, oe;
      xfer(0, RD, 5'h0B, 5'h00, 16'h0, 0, rd, ta, oe);
      chk("R9 first frame decoded", rd, 16'h2400);
      xfer(0, WR, 5'h0B, 5'h00, 16'h0000, 1, rd, ta, oe);
      chk("R9 gapless write ignored", 16'(isolate), 16'h1);
      xfer(0, RD, 5'h0B, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R9 control unchanged", rd, 16'h2400);
   endtask

   task automatic t_soft_reset;
      logic [15:0] rd; logic ta, oe;
      xfer(0, WR, 5'h0B, 5'h00, 16'h8000, 1, rd, ta, oe);
      xfer(0, RD, 5'h0B, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R10 soft reset restores default", rd, 16'h3100);
      chk("R10 isolate re-derived, addr 0B", 16'(isolate), 16'h0);
   endtask

   task automatic t_zero_addr;
      logic [15:0] rd; logic ta, oe;
      do_reset(5'h00);
      chk("R2 isolate after reset, addr 00", 16'(isolate), 16'h1);
      xfer(32, RD, 5'h00, 5'h00, 16'h0, 1, rd, ta, oe);
      chk("R11 read while isolated", rd, 16'h3500);
      xfer(0, RD, 5'h00, 5'h19, 16'h0, 1, rd, ta, oe);
      chk("R1 address register zero", rd, 16'h0000);
      xfer(0, WR, 5'h00, 5'h00, 16'h0000, 1, rd, ta, oe);
      chk("R11 write while isolated", 16'(isolate), 16'h0);
      xfer(0, WR, 5'h00, 5'h00, 16'h8000, 1, rd, ta, oe);
      chk("R10 isolate re-derived, addr 00", 16'(isolate), 16'h1);
   endtask

   initial begin
      t_reset_state();
      t_init();
      t_reads();
      t_write();
      t_mismatch();
      t_idle_gap();
      t_soft_reset();
      t_zero_addr();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule